// File: doc/BRIEF.md
# Link Noise Estimator and Protection Mode Selector

This block judges how noisy an on-chip link is and picks the protection mode that the link's encoder and decoder use. It drives a square-wave probe pattern (0, 1, 0, 1, ...) onto a dedicated monitor wire and watches what comes back on the receive side. Each cycle in which the returned bit differs from the bit driven in that same cycle counts as one error.

Errors are counted over a fixed window of 2^14 cycles. At the last cycle of each window the total is compared with two thresholds. A quiet link selects a lightweight single-error-correcting code on a shielded bus. A moderately noisy link selects a single-error-correcting, double-error-detecting code with retransmission, still shielded. A noisy link selects duplicated wires with the detecting code. The two-bit mode output feeds the encoder and decoder directly: bit 1 requests wire duplication (0 means shield wires) and bit 0 requests the double-error-detecting code (0 means correction only). The mode holds its value for the whole of the next window.

Top module: `noise_mode_ctrl`

## Requirements
- R1: After reset the probe output is 0, and it inverts on every clock cycle after that.
- R2: A cycle counts as one error exactly when `probe_rx` differs from `probe_tx` at the rising clock edge that ends that cycle.
- R3: A window is 16384 consecutive cycles, the first one beginning at reset release; `mode` changes only on the last edge of a window and holds its value throughout the next window.
- R4: A window total of 69 or more sets `mode` to 2'b11 (duplicated wires, detecting code).
- R5: A window total from 10 to 68 inclusive sets `mode` to 2'b01 (shielded, detecting code).
- R6: A window total below 10 sets `mode` to 2'b00 (shielded, correcting code); the value 2'b10 never appears.
- R7: The error count stops at 127 and does not wrap, so any total above 127 still selects 2'b11.
- R8: The error count restarts from zero in every window; errors from one window never carry into the next.
- R9: While reset is held and until the first window ends, `mode` is 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| probe_rx | input | 1 | Probe bit as received at the far end of the monitor wire |
| probe_tx | output | 1 | Alternating probe bit driven onto the monitor wire |
| mode | output | 2 | Protection mode: bit 1 duplication, bit 0 detecting code |

## Verification
A miscounting error counter, a wrong window length or a bad comparison shows at `mode` only on the last edge of a window, so each fault surfaces at most 16384 cycles after it happens. Totals placed on both sides of each threshold (9/10, 68/69) and a total above the counter range separate inclusive from exclusive compares and saturation from wrap-around. A window with no errors after a saturated one exposes a counter that fails to clear, and checking `mode` in the middle of a window exposes an early update.

// File: rtl/noise_mode_ctrl.sv
module noise_mode_ctrl #(
  parameter int WIN_BITS = 14,
  parameter int ERR_BITS = 7,
  parameter int THR_MID  = 10,
  parameter int THR_HIGH = 69
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       probe_rx,
  output logic       probe_tx,
  output logic [1:0] mode
);

  localparam logic [ERR_BITS-1:0] ERR_MAX = '1;
  localparam logic [ERR_BITS-1:0] LIM_MID = ERR_BITS'(THR_MID);
  localparam logic [ERR_BITS-1:0] LIM_HI  = ERR_BITS'(THR_HIGH);
  localparam logic [WIN_BITS-1:0] WIN_LAST = '1;

  logic [WIN_BITS-1:0] win_cnt;
  logic [ERR_BITS-1:0] err_cnt;
  logic [ERR_BITS-1:0] err_sum;
  logic                hit;
  logic                win_end;
  logic [1:0]          mode_next;

  assign hit     = probe_rx ^ probe_tx;
  assign win_end = (win_cnt == WIN_LAST);
  assign err_sum = (err_cnt == ERR_MAX) ? ERR_MAX : err_cnt + ERR_BITS'(hit);

  always_comb begin
    if (err_sum >= LIM_HI)       mode_next = 2'b11;
    else if (err_sum >= LIM_MID) mode_next = 2'b01;
    else                         mode_next = 2'b00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      probe_tx <= 1'b0;
      win_cnt  <= '0;
      err_cnt  <= '0;
      mode     <= 2'b11;
    end else begin
      probe_tx <= ~probe_tx;
      win_cnt  <= win_cnt + 1'b1;
      if (win_end) begin
        err_cnt <= '0;
        mode    <= mode_next;
      end else begin
        err_cnt <= err_sum;
      end
    end
  end

  AST_TX_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> probe_tx != $past(probe_tx)); // R1

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(win_end) |-> $stable(mode)); // R3

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b10); // R6

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(err_cnt) == ERR_MAX && !$past(win_end)) |-> err_cnt == ERR_MAX); // R7

  AST_WIN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(win_end)) |-> err_cnt == '0); // R8

  AST_HIGH_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(win_end) && $past(err_sum) >= LIM_HI) |-> mode == 2'b11); // R4

endmodule

// File: tb/noise_mode_ctrl_bench.sv
module noise_mode_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 16384;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       probe_rx = 1'b0;
  logic       probe_tx;
  logic [1:0] mode;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  noise_mode_ctrl u_noise_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .probe_rx(probe_rx),
    .probe_tx(probe_tx), .mode(mode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [1:0] exp_mode(int n);
    int s;
    s = (n > 127) ? 127 : n;
    if (s >= 69) return 2'b11;
    if (s >= 10) return 2'b01;
    return 2'b00;
  endfunction

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: mode actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // Runs one full window at negedge granularity, injecting n errors.
  task automatic run_window(string req, int n, logic [1:0] prev);
    int left;
    bit tog_ok;
    logic last_tx;
    left = n;
    tog_ok = 1'b1;
    last_tx = probe_tx;
    for (int i = 0; i < WIN; i++) begin
      bit inj;
      inj = (left > 0) && (($urandom % 97 == 0) || (left >= WIN - i));
      if (inj) left--;
      probe_rx = probe_tx ^ inj;
      if (i > 0 && probe_tx == last_tx) tog_ok = 1'b0;
      last_tx = probe_tx;
      if (i == WIN/2) check({req, " R3 mid-window hold"}, mode, prev);
      @(posedge clk);
      #1;
      @(negedge clk);
    end
    n_run++;
    if (!tog_ok) begin
      n_fail++;
      $display("FAIL R1: probe_tx actual=no-toggle expected=toggle");
    end
    check(req, mode, exp_mode(n));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [1:0] cur;
    int rn;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    n_run++;
    if (mode !== 2'b11 || probe_tx !== 1'b0) begin
      n_fail++;
      $display("FAIL R9: mode/tx actual=%b/%b expected=11/0", mode, probe_tx);
    end
    rst_n = 1'b1;
    cur = 2'b11;
    run_window("R6 zero errors", 0, cur);      cur = 2'b00;
    run_window("R5 at lower limit", 10, cur);  cur = 2'b01;
    run_window("R6 just below lower", 9, cur); cur = 2'b00;
    run_window("R4 at upper limit", 69, cur);  cur = 2'b11;
    run_window("R5 just below upper", 68, cur); cur = 2'b01;
    run_window("R7 saturate", 130, cur);       cur = 2'b11;
    run_window("R8 clear after saturate", 3, cur); cur = 2'b00;
    rn = $urandom_range(0, 127);
    run_window("R2 random count", rn, cur);
    finish_run();
  end
endmodule